// File: doc/BRIEF.md
# PCI/ISA Interrupt Wire Router

This block turns level-sensitive interrupt wires from PCI devices and ISA devices into a bank of global system interrupt (GSI) lines. The sources are not given as wires. They arrive as events. A PCI event names a device number and an INTx pin (A to D, encoded 0 to 3) together with the new level. An ISA event names an IRQ number together with the new level. The block keeps one state bit for every source wire. A counter moves only when that bit changes, so several wires can share a line as a wired-OR.

Every PCI wire takes part in two paths at the same time. In the first path, it folds onto one of four routing links. Each link can be programmed to reach one GSI, or to reach no GSI. In the second path, a fixed swizzle places it onto a dedicated GSI in the range 16 and up. An ISA IRQ drives the GSI with the same number, with one exception: IRQ 0 lands on GSI 2. The GSI levels go out as three groups. Lines 0 to 7 feed a primary cascade controller, lines 8 to 15 feed a secondary cascade controller, and the full vector feeds the advanced controller pins. The current link levels are also brought out.

Top module: `irq_wire_router`

## Requirements
- R1: After reset, every GSI line, every link level and every source state bit is low, and every link route is disabled.
- R2: A PCI wire for device d and pin p (A=0, B=1, C=2, D=3) raises GSI ((4*d + d/8 + p) mod 32) + 16. The line changes on the clock edge that samples the event, so it is visible one cycle after the event is applied.
- R3: A PCI wire joins link (d + p) mod 4. The link level is high while at least one wire of that link is asserted.
- R4: A route write (route_we with route_link, route_en and route_gsi) gives a link a target. A link drives its target GSI only when the route is enabled and the target is less than NUM_GSI. Otherwise the link drives no GSI.
- R5: ISA IRQ n drives GSI n for n from 1 to 15. ISA IRQ 0 drives GSI 2 and leaves GSI 0 untouched.
- R6: A GSI line is high while any source that feeds it is asserted. Those sources are ISA wires, dedicated PCI wires and routed links. The line falls only after the last such source is released.
- R7: An assert event for a wire that is already high has no effect. A deassert event for a wire that is already low has no effect. Neither one changes any counter.
- R8: If a link is asserted when it is re-routed, its contribution leaves the old GSI and reaches the new GSI on the same clock edge. This also holds when a PCI event for that link falls in the same cycle.
- R9: master_pic carries GSI 0 to 7, slave_pic carries GSI 8 to 15, and ioapic_pins carries all NUM_GSI lines.
- R10: Link counters and GSI counters are CNT_W bits wide (8 by default) and never wrap, either above or below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pci_valid | input | 1 | PCI wire event strobe |
| pci_dev | input | DEV_W | PCI device number |
| pci_pin | input | 2 | INTx pin, A=0 to D=3 |
| pci_level | input | 1 | New wire level, 1 = asserted |
| isa_valid | input | 1 | ISA wire event strobe |
| isa_irq | input | 4 | ISA IRQ number |
| isa_level | input | 1 | New wire level, 1 = asserted |
| route_we | input | 1 | Link route write strobe |
| route_link | input | 2 | Link being routed |
| route_en | input | 1 | Route enable |
| route_gsi | input | ROUTE_W | Target GSI number |
| master_pic | output | 8 | GSI 0 to 7 |
| slave_pic | output | 8 | GSI 8 to 15 |
| ioapic_pins | output | NUM_GSI | All GSI lines |
| link_level | output | 4 | Current level of each link |

## Verification
Some properties are checked by assertions on every cycle. A counter never wraps in either direction. A repeated assert of the same wire is never counted again. After an edge, the link and the dedicated GSI of a new PCI assertion are high. After an ISA IRQ 0 assertion, GSI 2 is high. Other behaviour needs whole scenarios to show it. These are the wired-OR release order across different kinds of source, the re-routing of a live link (including a route that is invalid or disabled), and the agreement of all GSI lines with a behavioural model through long random mixes of events and route writes.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

   localparam int LINKS         = 4;
   localparam int PINS_PER_DEV  = 4;
   localparam int ISA_IDX_W     = 4;
   localparam int PCI_GSI_FIRST = 16;
   localparam int PCI_GSI_SPAN  = 32;
   localparam int MIN_GSI       = PCI_GSI_FIRST + PCI_GSI_SPAN;

   // fixed swizzle of a PCI wire onto its dedicated GSI
   function automatic int pci_dedicated_gsi(int dev, int pin);
      return (((dev * PINS_PER_DEV) + (dev / 8) + pin) % PCI_GSI_SPAN) + PCI_GSI_FIRST;
   endfunction

   // barber's-pole fold of a PCI wire onto a routing link
   function automatic int pci_link_of(int dev, int pin);
      return (dev + pin) % LINKS;
   endfunction

   // ISA line to GSI, IRQ 0 redirected to 2
   function automatic int isa_to_gsi(int irq);
      return (irq == 0) ? 2 : irq;
   endfunction

endpackage

// File: rtl/irq_src_track.sv
module irq_src_track #(
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ev_valid,
   input  logic [IDX_W-1:0] ev_idx,
   input  logic             ev_level,
   output logic             rise,
   output logic             fall
);
   localparam int WIRES = 1 << IDX_W;

   logic [WIRES-1:0] st_q;

   assign rise = ev_valid &  ev_level & ~st_q[ev_idx];
   assign fall = ev_valid & ~ev_level &  st_q[ev_idx];

   always_ff @(posedge clk) begin
      if (!rst_n)
         st_q <= '0;
      else if (rise | fall)
         st_q[ev_idx] <= ev_level;
   end

   AST_REPEAT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !(rise && ev_valid && ev_level && ev_idx == $past(ev_idx)))
      else $error("repeated assert counted twice"); // R7

endmodule

// File: rtl/irq_link_bank.sv
module irq_link_bank #(
   parameter int CNT_W   = 8,
   parameter int ROUTE_W = 8,
   parameter int NUM_GSI = 48
) (
   input  logic                                           clk,
   input  logic                                           rst_n,
   input  logic                                           pci_rise,
   input  logic                                           pci_fall,
   input  logic [1:0]                                     pci_link,
   input  logic                                           cfg_we,
   input  logic [1:0]                                     cfg_link,
   input  logic                                           cfg_en,
   input  logic [ROUTE_W-1:0]                             cfg_gsi,
   output logic [irq_router_pkg::LINKS-1:0]               on_cur,
   output logic [irq_router_pkg::LINKS-1:0]               on_nxt,
   output logic [irq_router_pkg::LINKS-1:0]               ok_cur,
   output logic [irq_router_pkg::LINKS-1:0]               ok_nxt,
   output logic [irq_router_pkg::LINKS-1:0][ROUTE_W-1:0]  gsi_cur,
   output logic [irq_router_pkg::LINKS-1:0][ROUTE_W-1:0]  gsi_nxt
);
   import irq_router_pkg::*;

   localparam logic [ROUTE_W:0] GSI_LIM = (ROUTE_W+1)'(NUM_GSI);

   for (genvar l = 0; l < LINKS; l++) begin : g_link
      logic [CNT_W-1:0]   cnt_q, cnt_d;
      logic               en_q, en_d;
      logic [ROUTE_W-1:0] tgt_q, tgt_d;
      logic               hit;

      assign hit = (pci_link == 2'(l));

      always_comb begin
         cnt_d = cnt_q;
         if (pci_rise && hit)
            cnt_d = cnt_q + 1'b1;
         else if (pci_fall && hit)
            cnt_d = cnt_q - 1'b1;
      end

      always_comb begin
         en_d  = en_q;
         tgt_d = tgt_q;
         if (cfg_we && cfg_link == 2'(l)) begin
            en_d  = cfg_en;
            tgt_d = cfg_gsi;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cnt_q <= '0;
            en_q  <= 1'b0;
            tgt_q <= '0;
         end else begin
            cnt_q <= cnt_d;
            en_q  <= en_d;
            tgt_q <= tgt_d;
         end
      end

      assign on_cur[l]  = (cnt_q != '0);
      assign on_nxt[l]  = (cnt_d != '0);
      assign ok_cur[l]  = en_q && ({1'b0, tgt_q} < GSI_LIM);
      assign ok_nxt[l]  = en_d && ({1'b0, tgt_d} < GSI_LIM);
      assign gsi_cur[l] = tgt_q;
      assign gsi_nxt[l] = tgt_d;

      AST_LINK_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt_q == '1) |-> !(pci_rise && hit))
         else $error("link counter would wrap"); // R10
   end

   AST_LINK_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      pci_rise |=> on_cur[$past(pci_link)])
      else $error("link not raised by wire"); // R3

endmodule

// File: rtl/irq_gsi_bank.sv
module irq_gsi_bank #(
   parameter int NUM_GSI   = 48,
   parameter int CNT_W     = 8,
   parameter int ROUTE_W   = 8,
   parameter int GSI_IDX_W = 6
) (
   input  logic                                          clk,
   input  logic                                          rst_n,
   input  logic                                          isa_rise,
   input  logic                                          isa_fall,
   input  logic [GSI_IDX_W-1:0]                          isa_gsi,
   input  logic                                          pci_rise,
   input  logic                                          pci_fall,
   input  logic [GSI_IDX_W-1:0]                          pci_gsi,
   input  logic [irq_router_pkg::LINKS-1:0]              on_cur,
   input  logic [irq_router_pkg::LINKS-1:0]              on_nxt,
   input  logic [irq_router_pkg::LINKS-1:0]              ok_cur,
   input  logic [irq_router_pkg::LINKS-1:0]              ok_nxt,
   input  logic [irq_router_pkg::LINKS-1:0][ROUTE_W-1:0] gsi_cur,
   input  logic [irq_router_pkg::LINKS-1:0][ROUTE_W-1:0] gsi_nxt,
   output logic [NUM_GSI-1:0]                            gsi_level
);
   import irq_router_pkg::*;

   for (genvar g = 0; g < NUM_GSI; g++) begin : g_gsi
      logic [CNT_W-1:0] cnt_q, cnt_d;
      int               delta;

      always_comb begin
         delta = 0;
         if (isa_rise && isa_gsi == GSI_IDX_W'(g)) delta = delta + 1;
         if (isa_fall && isa_gsi == GSI_IDX_W'(g)) delta = delta - 1;
         if (pci_rise && pci_gsi == GSI_IDX_W'(g)) delta = delta + 1;
         if (pci_fall && pci_gsi == GSI_IDX_W'(g)) delta = delta - 1;
         for (int l = 0; l < LINKS; l++) begin
            if (on_cur[l] && ok_cur[l] && gsi_cur[l] == ROUTE_W'(g)) delta = delta - 1;
            if (on_nxt[l] && ok_nxt[l] && gsi_nxt[l] == ROUTE_W'(g)) delta = delta + 1;
         end
         cnt_d = cnt_q + CNT_W'(delta);
      end

      always_ff @(posedge clk) begin
         if (!rst_n) cnt_q <= '0;
         else        cnt_q <= cnt_d;
      end

      assign gsi_level[g] = (cnt_q != '0);

      AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt_q == '0) |-> (delta >= 0))
         else $error("GSI counter underflow"); // R10
      AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt_q == '1) |-> (delta <= 0))
         else $error("GSI counter overflow"); // R10
   end

endmodule

// File: rtl/irq_wire_router.sv
module irq_wire_router #(
   parameter int DEV_W   = 5,
   parameter int NUM_GSI = 48,
   parameter int CNT_W   = 8,
   parameter int ROUTE_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pci_valid,
   input  logic [DEV_W-1:0]   pci_dev,
   input  logic [1:0]         pci_pin,
   input  logic               pci_level,
   input  logic               isa_valid,
   input  logic [3:0]         isa_irq,
   input  logic               isa_level,
   input  logic               route_we,
   input  logic [1:0]         route_link,
   input  logic               route_en,
   input  logic [ROUTE_W-1:0] route_gsi,
   output logic [7:0]         master_pic,
   output logic [7:0]         slave_pic,
   output logic [NUM_GSI-1:0] ioapic_pins,
   output logic [3:0]         link_level
);
   import irq_router_pkg::*;

   localparam int GSI_IDX_W = $clog2(NUM_GSI);
   localparam int PCI_IDX_W = DEV_W + 2;

   if (NUM_GSI < MIN_GSI || NUM_GSI > 256) begin : g_bad_gsi
      $error("NUM_GSI must lie in 48..256");
   end
   if (DEV_W < 3 || DEV_W > 8) begin : g_bad_dev
      $error("DEV_W must lie in 3..8");
   end
   if (CNT_W < 4) begin : g_bad_cnt
      $error("CNT_W must be at least 4");
   end
   if (ROUTE_W < GSI_IDX_W) begin : g_bad_route
      $error("ROUTE_W too narrow for NUM_GSI");
   end

   logic                      pci_rise, pci_fall, isa_rise, isa_fall;
   logic [GSI_IDX_W-1:0]      ded_gsi, isa_gsi;
   logic [1:0]                link_sel;
   logic [LINKS-1:0]          on_cur, on_nxt, ok_cur, ok_nxt;
   logic [LINKS-1:0][ROUTE_W-1:0] gsi_cur, gsi_nxt;
   logic [NUM_GSI-1:0]        gsi_level;

   assign ded_gsi  = GSI_IDX_W'(pci_dedicated_gsi(int'(pci_dev), int'(pci_pin)));
   assign link_sel = 2'(pci_link_of(int'(pci_dev), int'(pci_pin)));
   assign isa_gsi  = GSI_IDX_W'(isa_to_gsi(int'(isa_irq)));

   irq_src_track #(.IDX_W(PCI_IDX_W)) u_pci_src (
      .clk(clk), .rst_n(rst_n), .ev_valid(pci_valid), .ev_idx({pci_dev, pci_pin}),
      .ev_level(pci_level), .rise(pci_rise), .fall(pci_fall));

   irq_src_track #(.IDX_W(ISA_IDX_W)) u_isa_src (
      .clk(clk), .rst_n(rst_n), .ev_valid(isa_valid), .ev_idx(isa_irq),
      .ev_level(isa_level), .rise(isa_rise), .fall(isa_fall));

   irq_link_bank #(.CNT_W(CNT_W), .ROUTE_W(ROUTE_W), .NUM_GSI(NUM_GSI)) u_links (
      .clk(clk), .rst_n(rst_n), .pci_rise(pci_rise), .pci_fall(pci_fall), .pci_link(link_sel),
      .cfg_we(route_we), .cfg_link(route_link), .cfg_en(route_en), .cfg_gsi(route_gsi),
      .on_cur(on_cur), .on_nxt(on_nxt), .ok_cur(ok_cur), .ok_nxt(ok_nxt),
      .gsi_cur(gsi_cur), .gsi_nxt(gsi_nxt));

   irq_gsi_bank #(.NUM_GSI(NUM_GSI), .CNT_W(CNT_W), .ROUTE_W(ROUTE_W),
                  .GSI_IDX_W(GSI_IDX_W)) u_gsis (
      .clk(clk), .rst_n(rst_n), .isa_rise(isa_rise), .isa_fall(isa_fall), .isa_gsi(isa_gsi),
      .pci_rise(pci_rise), .pci_fall(pci_fall), .pci_gsi(ded_gsi),
      .on_cur(on_cur), .on_nxt(on_nxt), .ok_cur(ok_cur), .ok_nxt(ok_nxt),
      .gsi_cur(gsi_cur), .gsi_nxt(gsi_nxt), .gsi_level(gsi_level));

   assign master_pic  = gsi_level[7:0];
   assign slave_pic   = gsi_level[15:8];
   assign ioapic_pins = gsi_level;
   assign link_level  = on_cur;

   AST_ISA0_TO_GSI2: assert property (@(posedge clk) disable iff (!rst_n)
      (isa_rise && isa_irq == 4'd0) |=> ioapic_pins[2])
      else $error("ISA IRQ 0 did not reach GSI 2"); // R5
   AST_PCI_DEDICATED: assert property (@(posedge clk) disable iff (!rst_n)
      pci_rise |=> gsi_level[$past(ded_gsi)])
      else $error("dedicated GSI not raised"); // R2

endmodule

// File: tb/irq_wire_router_test.sv
module irq_wire_router_test;
   localparam int NG = 48;

   logic clk = 1'b0, rst_n = 1'b0;
   logic pci_valid = 0, pci_level = 0, isa_valid = 0, isa_level = 0;
   logic route_we = 0, route_en = 0;
   logic [4:0] pci_dev = '0;
   logic [1:0] pci_pin = '0, route_link = '0;
   logic [3:0] isa_irq = '0;
   logic [7:0] route_gsi = '0;
   logic [7:0] master_pic, slave_pic;
   logic [NG-1:0] ioapic_pins;
   logic [3:0] link_level;

   int checks = 0, errors = 0;
   bit done = 0;

   bit pci_st[128];
   bit isa_st[16];
   bit men[4];
   int mg[4];
   logic [NG-1:0] exp_g;
   logic [3:0]    exp_l;

   always #10 clk = ~clk;

   irq_wire_router uut (.*);

   function automatic int ded(int d, int p);
      return ((d * 4 + d / 8 + p) % 32) + 16;
   endfunction

   task automatic model_apply();
      if (!rst_n) begin
         foreach (pci_st[i]) pci_st[i] = 0;
         foreach (isa_st[i]) isa_st[i] = 0;
         foreach (men[i]) begin men[i] = 0; mg[i] = 0; end
      end else begin
         if (pci_valid) pci_st[int'(pci_dev) * 4 + int'(pci_pin)] = pci_level;
         if (isa_valid) isa_st[isa_irq] = isa_level;
         if (route_we) begin men[route_link] = route_en; mg[route_link] = int'(route_gsi); end
      end
      exp_g = '0;
      exp_l = '0;
      for (int w = 0; w < 128; w++)
         if (pci_st[w]) begin
            exp_l[((w / 4) + (w % 4)) % 4] = 1'b1;
            exp_g[ded(w / 4, w % 4)] = 1'b1;
         end
      for (int i = 0; i < 16; i++)
         if (isa_st[i]) exp_g[(i == 0) ? 2 : i] = 1'b1;
      for (int l = 0; l < 4; l++)
         if (exp_l[l] && men[l] && mg[l] < NG) exp_g[mg[l]] = 1'b1;
   endtask

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   // advance one clock; model follows the edge; compare at the falling edge
   task automatic tick(string tag);
      @(posedge clk);
      model_apply();
      @(negedge clk);
      chk({tag, " ioapic"}, 64'(ioapic_pins), 64'(exp_g));
      chk("R9 master_pic", 64'(master_pic), 64'(exp_g[7:0]));
      chk("R9 slave_pic", 64'(slave_pic), 64'(exp_g[15:8]));
      chk("R3 link_level", 64'(link_level), 64'(exp_l));
      pci_valid = 0; isa_valid = 0; route_we = 0;
   endtask

   task automatic pci(int d, int p, bit lv);
      pci_valid = 1; pci_dev = 5'(d); pci_pin = 2'(p); pci_level = lv;
   endtask
   task automatic isa(int n, bit lv);
      isa_valid = 1; isa_irq = 4'(n); isa_level = lv;
   endtask
   task automatic route(int l, bit en, int g);
      route_we = 1; route_link = 2'(l); route_en = en; route_gsi = 8'(g);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual hung expected finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      tick("R1 reset");
      tick("R1 reset");
      rst_n = 1;
      chk("R1 all GSI low", 64'(ioapic_pins), 64'd0);
      chk("R1 links low", 64'(link_level), 64'd0);

      route(0, 1, 10); tick("R4 cfg");
      route(1, 1, 11); tick("R4 cfg");
      route(2, 1, 40); tick("R4 cfg");
      route(3, 1, 60); tick("R4 cfg");
      chk("R4 routing alone drives nothing", 64'(ioapic_pins), 64'd0);

      pci(3, 1, 1); tick("R2");
      chk("R2 dedicated GSI 29", 64'(ioapic_pins[29]), 64'd1);
      chk("R3 link0 only", 64'(link_level), 64'h1);
      chk("R4 link0 to GSI 10", 64'(slave_pic[2]), 64'd1);
      chk("R9 master quiet", 64'(master_pic), 64'd0);

      pci(4, 0, 1); tick("R2");
      chk("R2 dedicated GSI 32", 64'(ioapic_pins[32]), 64'd1);
      pci(3, 1, 0); tick("R6");
      chk("R6 GSI 10 held by other wire", 64'(ioapic_pins[10]), 64'd1);
      chk("R6 GSI 29 released", 64'(ioapic_pins[29]), 64'd0);
      pci(4, 0, 0); tick("R6");
      chk("R6 GSI 10 released", 64'(ioapic_pins[10]), 64'd0);
      chk("R6 links released", 64'(link_level), 64'd0);

      pci(3, 1, 1); tick("R7");
      pci(3, 1, 1); tick("R7");
      pci(3, 1, 0); tick("R7");
      chk("R7 repeat assert ignored", 64'(ioapic_pins), 64'd0);
      pci(5, 2, 0); tick("R7");
      chk("R7 idle deassert ignored", 64'(ioapic_pins), 64'd0);
      pci(5, 2, 1); tick("R7");
      chk("R7 counter intact GSI 38", 64'(ioapic_pins[38]), 64'd1);
      pci(5, 2, 0); tick("R7");

      pci(0, 3, 1); tick("R4");
      chk("R4 invalid target ignored", 64'(ioapic_pins), 64'(1) << 19);
      chk("R3 link3", 64'(link_level), 64'h8);
      route(3, 0, 5); tick("R4");
      chk("R4 disabled route ignored", 64'(ioapic_pins[5]), 64'd0);
      route(3, 1, 5); tick("R8");
      chk("R8 enable moves link in", 64'(ioapic_pins[5]), 64'd1);
      pci(0, 3, 0); tick("R6");
      chk("R6 all released", 64'(ioapic_pins), 64'd0);

      isa(0, 1); tick("R5");
      chk("R5 IRQ0 to GSI 2", 64'(master_pic), 64'h4);
      isa(10, 1); tick("R5");
      chk("R5 IRQ10 to GSI 10", 64'(slave_pic), 64'h4);
      pci(3, 1, 1); tick("R6");
      isa(10, 0); tick("R6");
      chk("R6 GSI 10 held by link", 64'(ioapic_pins[10]), 64'd1);

      route(0, 1, 12); tick("R8");
      chk("R8 remap moves contribution", 64'(slave_pic), 64'h10);
      route(0, 1, 13); pci(3, 1, 0); tick("R8");
      chk("R8 remap with release", 64'(slave_pic), 64'h0);
      isa(0, 0); tick("R5");
      chk("R5 IRQ0 released", 64'(ioapic_pins), 64'd0);

      for (int n = 0; n < 4000; n++) begin
         if ($urandom_range(0, 1) == 1) pci($urandom_range(0, 31), $urandom_range(0, 3), 1'($urandom_range(0, 1)));
         if ($urandom_range(0, 2) == 0) isa($urandom_range(0, 15), 1'($urandom_range(0, 1)));
         if ($urandom_range(0, 7) == 0) route($urandom_range(0, 3), 1'($urandom_range(0, 3) != 0), $urandom_range(0, 63));
         tick("R6 random");
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule